// File: doc/BRIEF.md
# Debug RAM and Flag Block for Hart Debug Access

This block is the part of a hart debug unit that sits between a debug transport and one processor hart. The transport reaches it over a plain request/address/data bus with 34-bit words. The block holds a small scratch memory that both sides share, a control register and a read-only capability register. It also keeps two status flags: a debug-interrupt request to the hart and a flag that tells whether the hart is halted.

A debugger loads a short routine into the scratch memory from the bus. It raises the interrupt with the top bit of the bus word, and the hart then runs that routine from its own view of the memory at byte address 0x400. The hart pulses a done input when the routine ends, and this clears the interrupt. Every bus read of a memory word or of the control register returns both flags in the top two bits, so one read fetches data and status together. The hart's halt-entry and resume events set and clear the halted flag. Hart accesses outside the memory window, including the ROM region from 0x800 that lies elsewhere, get zero from this block.

Top module: `dm_debug_ram`

## Requirements
- R1: Memory word i with i < 16 sits at bus address i. A bus write stores bits 31:0, and a bus read returns the word in bus_rdata one clock after the request.
- R2: Memory word i with i >= 16 sits at bus address 0x40 + (i - 16). The two windows never alias each other.
- R3: A bus read of a memory word or of the control register (0x10) returns the interrupt flag in bit 33 and the halted flag in bit 32, both taken as they stood in the cycle of the request. A read of the capability register returns zero in bits 33:32.
- R4: A bus write with bit 33 set, to a memory word or to the control register, sets debug_irq on the next clock. A bus write with bit 33 clear leaves debug_irq unchanged.
- R5: A hart_done pulse clears debug_irq on the next clock. When a setting bus write and hart_done fall in the same cycle, debug_irq ends set.
- R6: A hart_halt pulse sets halted and a hart_resume pulse clears it. Bit 32 of a bus write has no effect on halted.
- R7: The control register at 0x10 stores written bits 21:19 (bus error), 15 (auto-increment), 14:12 (access size), 11:2 (hart id), 1 (ndreset) and 0 (fullreset). Every other bit of bits 31:0 reads back as zero.
- R8: The capability register at 0x11 reads RAM_WORDS-1 in bits 15:10, the supported access sizes 8/16/32/64/128 as bits 16 to 20 (ACCESS_MASK), authentication type 0 in bits 3:2 and VERSION in bits 1:0. All other bits read zero, and writes to it are ignored.
- R9: On the hart port, word i sits at byte address 0x400 + 4*i, and hart_rdata returns it one clock after a read request. A hart access outside that window reads zero and writes nothing.
- R10: When the bus and the hart write the same word in one cycle, the bus value is kept. A hart read of a word that the bus writes in the same cycle returns the old value.
- R11: A synchronous active-low reset clears debug_irq, halted, the control register, bus_rdata and hart_rdata. Memory contents are not reset.
- R12: A bus read of an unmapped address returns zero, and a bus write to one changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Bus word address |
| bus_wdata | input | 34 | Write word: bit 33 interrupt request, bit 32 ignored, bits 31:0 data |
| bus_rdata | output | 34 | Read word, valid the cycle after a read request and held until the next one |
| hart_req | input | 1 | Hart memory access request |
| hart_we | input | 1 | Hart write enable |
| hart_addr | input | HART_AW | Hart byte address |
| hart_wdata | input | 32 | Hart write data |
| hart_rdata | output | 32 | Hart read data, one cycle after the request |
| hart_halt | input | 1 | Pulse: the hart entered the halted state |
| hart_resume | input | 1 | Pulse: the hart left the halted state |
| hart_done | input | 1 | Pulse: the hart finished the debug routine |
| debug_irq | output | 1 | Debug interrupt request to the hart |
| halted | output | 1 | Halted flag |

## Verification
The bench writes words through both windows before it reads any back. A decoder that folds the upper window onto the lower one, or that offsets it wrongly, would then return another word's data. It checks that bit 32 of a bus write leaves the halted flag alone and that a clearing write leaves the interrupt set; a design that copied flag bits from the bus word would lose or invent a halt. It puts a bus write in the same cycle as a hart write, as a hart read and as hart_done. A wrong priority would keep the hart value, return new data too early or drop an interrupt request. It ends with a reset in mid-run, which must clear the flags and the control register.

// File: rtl/dm_pkg.sv
// Package: shared constants and address-decode helpers for the debug RAM block.
// Assumes 32-bit memory words carried in a 34-bit bus word.
package dm_pkg;
    localparam int DATA_W        = 32;
    localparam int BUS_W         = DATA_W + 2;
    localparam int IRQ_BIT       = DATA_W + 1;
    localparam int LOW_WIN_WORDS = 16;
    localparam int HIGH_WIN_BASE = 'h40;
    localparam int CTRL_ADDR     = 'h10;
    localparam int INFO_ADDR     = 'h11;
    localparam int HART_RAM_BASE = 'h400;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0038_FFFF;

    // True when a bus address selects a memory word.
    function automatic logic bus_ram_hit(input int addr, input int words);
        if (addr < LOW_WIN_WORDS)
            return addr < words;
        return (words > LOW_WIN_WORDS) && (addr >= HIGH_WIN_BASE) &&
               (addr - HIGH_WIN_BASE + LOW_WIN_WORDS < words);
    endfunction

    // Word index for a bus address that hits memory.
    function automatic int bus_ram_index(input int addr);
        return (addr < LOW_WIN_WORDS) ? addr : addr - HIGH_WIN_BASE + LOW_WIN_WORDS;
    endfunction
endpackage

// File: rtl/dm_ram.sv
// Module: shared scratch memory with one bus port and one hart port.
// Reads are combinational; the top registers them. On a same-word write
// collision the bus port (port A) wins. Contents are never reset.
module dm_ram #(
    parameter int WORDS  = 20,
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [IDX_W-1:0]  a_idx,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_we,
    input  logic [IDX_W-1:0]  b_idx,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // Write both ports; the later bus assignment overrides the hart on a collision.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_idx] <= b_wdata;
        if (a_we) mem[a_idx] <= a_wdata;
    end

    assign a_rdata = mem[a_idx];
    assign b_rdata = mem[b_idx];
endmodule

// File: rtl/dm_flags.sv
// Module: the debug-interrupt and halted status flags.
// Assumes pulse inputs of one cycle. Setting wins over clearing in either flag.
module dm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_set,
    input  logic irq_clr,
    input  logic halt_set,
    input  logic halt_clr,
    output logic irq_q,
    output logic halt_q
);
    // Interrupt request: raised by the bus, dropped by the hart's done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (irq_set)  irq_q <= 1'b1;
        else if (irq_clr)  irq_q <= 1'b0;
    end

    // Halted flag: follows the hart's halt-entry and resume pulses only.
    always_ff @(posedge clk) begin
        if (!rst_n)        halt_q <= 1'b0;
        else if (halt_set) halt_q <= 1'b1;
        else if (halt_clr) halt_q <= 1'b0;
    end
endmodule

// File: rtl/dm_ctrl.sv
// Module: control register storage and the constant capability word.
// Assumes the write strobe is already decoded. Unimplemented bits read zero.
module dm_ctrl
    import dm_pkg::*;
#(
    parameter int         RAM_WORDS   = 20,
    parameter logic [4:0] ACCESS_MASK = 5'b00100,
    parameter logic [1:0] VERSION     = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] info_word
);
    localparam logic [5:0] SIZE_FIELD = 6'(RAM_WORDS - 1);

    // Control register: keep the implemented fields only.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata & CTRL_WMASK;
    end

    // Capability word: size, access sizes, auth type (none) and version.
    always_comb begin
        info_word        = '0;
        info_word[20:16] = ACCESS_MASK;
        info_word[15:10] = SIZE_FIELD;
        info_word[3:2]   = 2'd0;
        info_word[1:0]   = VERSION;
    end
endmodule

// File: rtl/dm_debug_ram.sv
// Module: top of the debug RAM block. Decodes the bus and hart addresses,
// raises the interrupt request and assembles registered read data.
// Assumes single-cycle requests on both ports and RAM_WORDS in 2..64.
module dm_debug_ram
    import dm_pkg::*;
#(
    parameter int         RAM_WORDS   = 20,
    parameter int         ADDR_W      = 7,
    parameter int         HART_AW     = 12,
    parameter logic [4:0] ACCESS_MASK = 5'b00100,
    parameter logic [1:0] VERSION     = 2'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [33:0]        bus_wdata,
    output logic [33:0]        bus_rdata,
    input  logic               hart_req,
    input  logic               hart_we,
    input  logic [HART_AW-1:0] hart_addr,
    input  logic [31:0]        hart_wdata,
    output logic [31:0]        hart_rdata,
    input  logic               hart_halt,
    input  logic               hart_resume,
    input  logic               hart_done,
    output logic               debug_irq,
    output logic               halted
);
    localparam int IDX_W = $clog2(RAM_WORDS);

    logic              bus_ram_sel, bus_ctrl_sel, bus_info_sel;
    logic [IDX_W-1:0]  bus_idx, hart_idx;
    logic              hart_ram_sel;
    logic [DATA_W-1:0] ram_bus_q, ram_hart_q, ctrl_q, info_word;
    logic              bus_wr, bus_rd;

    // Bus address decode into memory, control and capability selects.
    always_comb begin
        bus_ram_sel  = bus_ram_hit(int'(bus_addr), RAM_WORDS);
        bus_ctrl_sel = (int'(bus_addr) == CTRL_ADDR);
        bus_info_sel = (int'(bus_addr) == INFO_ADDR);
        bus_idx      = IDX_W'(bus_ram_index(int'(bus_addr)));
    end

    // Hart address decode: word-aligned window starting at HART_RAM_BASE.
    always_comb begin
        hart_ram_sel = (int'(hart_addr) >= HART_RAM_BASE) &&
                       (int'(hart_addr) <  HART_RAM_BASE + 4 * RAM_WORDS);
        hart_idx     = IDX_W'((int'(hart_addr) - HART_RAM_BASE) / 4);
    end

    assign bus_wr = bus_req &&  bus_we;
    assign bus_rd = bus_req && !bus_we;

    dm_ram #(.WORDS(RAM_WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .a_we    (bus_wr && bus_ram_sel),
        .a_idx   (bus_idx),
        .a_wdata (bus_wdata[DATA_W-1:0]),
        .a_rdata (ram_bus_q),
        .b_we    (hart_req && hart_we && hart_ram_sel),
        .b_idx   (hart_idx),
        .b_wdata (hart_wdata),
        .b_rdata (ram_hart_q)
    );

    dm_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_set  (bus_wr && bus_wdata[IRQ_BIT] && (bus_ram_sel || bus_ctrl_sel)),
        .irq_clr  (hart_done),
        .halt_set (hart_halt),
        .halt_clr (hart_resume),
        .irq_q    (debug_irq),
        .halt_q   (halted)
    );

    dm_ctrl #(.RAM_WORDS(RAM_WORDS), .ACCESS_MASK(ACCESS_MASK), .VERSION(VERSION)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && bus_ctrl_sel),
        .wdata     (bus_wdata[DATA_W-1:0]),
        .ctrl_q    (ctrl_q),
        .info_word (info_word)
    );

    // Bus read data: flags ride along with memory and control reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd) begin
            if (bus_ram_sel)       bus_rdata <= {debug_irq, halted, ram_bus_q};
            else if (bus_ctrl_sel) bus_rdata <= {debug_irq, halted, ctrl_q};
            else if (bus_info_sel) bus_rdata <= {2'b00, info_word};
            else                   bus_rdata <= '0;
        end
    end

    // Hart read data: old contents on a same-cycle bus write, zero outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hart_rdata <= '0;
        else if (hart_req && !hart_we)
            hart_rdata <= hart_ram_sel ? ram_hart_q : '0;
    end
endmodule

// File: rtl/dm_debug_ram_chk.sv
// Checker: temporal properties of the flags and reset, bound to the top.
module dm_debug_ram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic [33:0] bus_wdata,
    input logic [33:0] bus_rdata,
    input logic        hart_halt,
    input logic        hart_resume,
    input logic        hart_done,
    input logic        debug_irq,
    input logic        halted
);
    // R4: the interrupt only rises after a bus write carrying bit 33.
    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(debug_irq) |-> $past(bus_req && bus_we && bus_wdata[33]));

    // R4: without a done pulse the interrupt stays set.
    assert_irq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_irq && !hart_done) |=> debug_irq);

    // R5: the interrupt only falls after a done pulse.
    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(debug_irq) |-> $past(hart_done));

    // R6: halted rises only on a halt pulse.
    assert_halt_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(hart_halt));

    // R6: halted falls only on a resume pulse.
    assert_halt_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> $past(hart_resume));

    // R11: a reset cycle leaves flags and read data cleared.
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (!debug_irq && !halted && bus_rdata == 34'd0));
endmodule

bind dm_debug_ram dm_debug_ram_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .hart_halt   (hart_halt),
    .hart_resume (hart_resume),
    .hart_done   (hart_done),
    .debug_irq   (debug_irq),
    .halted      (halted)
);

// File: tb/sim_dm_debug_ram.sv
`timescale 1ns/1ps
module sim_dm_debug_ram;
    localparam int         RAM_WORDS = 20;
    localparam logic [4:0] ACC       = 5'b00100;
    localparam logic [1:0] VER       = 2'd1;
    localparam int         NV        = 7;

    // Stimulus table: all writes first, then all reads, to expose aliasing.
    // Rows 0-2 low window (R1), 3-4 high window (R2), 5 control with bit 32 set (R7, R6), 6 unmapped (R12).
    localparam logic [6:0]  T_ADDR [NV] = '{7'h00, 7'h05, 7'h0F, 7'h40, 7'h43, 7'h10, 7'h20};
    localparam logic [33:0] T_WR   [NV] = '{34'h0_1234_5678, 34'h0_DEAD_BEEF, 34'h0_0000_0001,
                                            34'h0_A5A5_5A5A, 34'h0_FFFF_0000, 34'h1_FFFF_FFFF,
                                            34'h0_CAFE_F00D};
    localparam logic [33:0] T_EXP  [NV] = '{34'h0_1234_5678, 34'h0_DEAD_BEEF, 34'h0_0000_0001,
                                            34'h0_A5A5_5A5A, 34'h0_FFFF_0000, 34'h0_0038_FFFF,
                                            34'h0_0000_0000};
    localparam int          T_REQ  [NV] = '{1, 1, 1, 2, 2, 7, 12};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [33:0] bus_wdata = '0;
    logic [33:0] bus_rdata;
    logic        hart_req = 1'b0, hart_we = 1'b0;
    logic [11:0] hart_addr = '0;
    logic [31:0] hart_wdata = '0;
    logic [31:0] hart_rdata;
    logic        hart_halt = 1'b0, hart_resume = 1'b0, hart_done = 1'b0;
    logic        debug_irq, halted;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dm_debug_ram #(.RAM_WORDS(RAM_WORDS), .ACCESS_MASK(ACC), .VERSION(VER)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hart_req(hart_req), .hart_we(hart_we), .hart_addr(hart_addr),
        .hart_wdata(hart_wdata), .hart_rdata(hart_rdata),
        .hart_halt(hart_halt), .hart_resume(hart_resume), .hart_done(hart_done),
        .debug_irq(debug_irq), .halted(halted)
    );

    task automatic chk(input logic [33:0] act, input logic [33:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [33:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic hart_op(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        hart_req = 1'b1; hart_we = we; hart_addr = a; hart_wdata = d;
        @(negedge clk);
        hart_req = 1'b0; hart_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk({32'd0, debug_irq, halted}, 34'd0, "R11 flags after reset");
        chk(bus_rdata, 34'd0, "R11 bus_rdata after reset");
        chk({2'b00, hart_rdata}, 34'd0, "R11 hart_rdata after reset");
        bus_read(7'h10);
        chk(bus_rdata, 34'd0, "R11 control after reset");

        // Table walk: writes, then reads
        for (int i = 0; i < NV; i++) bus_write(T_ADDR[i], T_WR[i]);
        for (int i = 0; i < NV; i++) begin
            bus_read(T_ADDR[i]);
            chk(bus_rdata, T_EXP[i], $sformatf("R%0d table row %0d", T_REQ[i], i));
        end
        // R6: bit 32 in the control write left halted clear
        chk({33'd0, halted}, 34'd0, "R6 bus bit 32 ignored");

        // R8: capability word
        bus_read(7'h11);
        chk(bus_rdata, (34'(RAM_WORDS - 1) << 10) | (34'(ACC) << 16) | 34'(VER), "R8 info word");
        bus_write(7'h11, 34'h0_0000_0000);
        bus_read(7'h11);
        chk(bus_rdata, (34'(RAM_WORDS - 1) << 10) | (34'(ACC) << 16) | 34'(VER), "R8 info write ignored");

        // R9: hart view of the memory
        hart_op(1'b0, 12'h414, '0);
        chk({2'b00, hart_rdata}, 34'h0_DEAD_BEEF, "R9 hart read word 5");
        hart_op(1'b0, 12'h440, '0);
        chk({2'b00, hart_rdata}, 34'h0_A5A5_5A5A, "R9 hart read word 16");
        hart_op(1'b1, 12'h41C, 32'h0000_0077);
        bus_read(7'h07);
        chk(bus_rdata, 34'h0_0000_0077, "R9 hart write seen on bus");
        hart_op(1'b1, 12'h450, 32'h0000_0099);
        hart_op(1'b0, 12'h450, '0);
        chk({2'b00, hart_rdata}, 34'd0, "R9 beyond window reads zero");
        hart_op(1'b0, 12'h804, '0);
        chk({2'b00, hart_rdata}, 34'd0, "R9 rom region reads zero");

        // R10: same-cycle collisions on word 3
        bus_write(7'h03, 34'h0_0000_0011);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 7'h03; bus_wdata = 34'h0_0000_0022;
        hart_req = 1'b1; hart_we = 1'b0; hart_addr = 12'h40C;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; hart_req = 1'b0;
        chk({2'b00, hart_rdata}, 34'h0_0000_0011, "R10 hart read returns old value");
        bus_read(7'h03);
        chk(bus_rdata, 34'h0_0000_0022, "R10 bus write landed");
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 7'h03; bus_wdata = 34'h0_0000_0033;
        hart_req = 1'b1; hart_we = 1'b1; hart_addr = 12'h40C; hart_wdata = 32'h0000_0044;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; hart_req = 1'b0; hart_we = 1'b0;
        bus_read(7'h03);
        chk(bus_rdata, 34'h0_0000_0033, "R10 bus wins write collision");

        // R6: halt pulse, flags on a memory read (R3)
        @(negedge clk); hart_halt = 1'b1;
        @(negedge clk); hart_halt = 1'b0;
        chk({33'd0, halted}, 34'd1, "R6 halt pulse sets halted");
        bus_read(7'h00);
        chk(bus_rdata, 34'h1_1234_5678, "R3 halted in bit 32");
        bus_write(7'h10, 34'h0_0000_0000);
        chk({33'd0, halted}, 34'd1, "R6 bus bit 32 clear keeps halted");

        // R4: raise the interrupt
        bus_write(7'h01, 34'h2_0000_00AA);
        chk({33'd0, debug_irq}, 34'd1, "R4 bit 33 write raises irq");
        bus_read(7'h01);
        chk(bus_rdata, 34'h3_0000_00AA, "R3 both flags on memory read");
        bus_read(7'h10);
        chk(bus_rdata, 34'h3_0000_0000, "R3 both flags on control read");
        bus_write(7'h02, 34'h0_0000_0000);
        chk({33'd0, debug_irq}, 34'd1, "R4 clear bit 33 leaves irq set");

        // R5: set and done together, then done alone
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 7'h41; bus_wdata = 34'h2_0000_0000;
        hart_done = 1'b1;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; hart_done = 1'b0;
        chk({33'd0, debug_irq}, 34'd1, "R5 set wins over done");
        @(negedge clk); hart_done = 1'b1;
        @(negedge clk); hart_done = 1'b0;
        chk({33'd0, debug_irq}, 34'd0, "R5 done clears irq");
        @(negedge clk); hart_resume = 1'b1;
        @(negedge clk); hart_resume = 1'b0;
        chk({33'd0, halted}, 34'd0, "R6 resume clears halted");

        // R11: reset in mid-run
        bus_write(7'h10, 34'h2_0000_1234);
        @(negedge clk); hart_halt = 1'b1;
        @(negedge clk); hart_halt = 1'b0;
        bus_read(7'h10);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk({32'd0, debug_irq, halted}, 34'd0, "R11 flags cleared by reset");
        chk(bus_rdata, 34'd0, "R11 bus_rdata cleared by reset");
        bus_read(7'h10);
        chk(bus_rdata, 34'd0, "R11 control cleared by reset");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule